// File: doc/BRIEF.md
# Jitter-Sample XOR Post-Processor

This block is the digital back end of a random bit generator that gets its randomness from clock jitter. On every system clock it receives a vector of tap samples. Each tap is a synchronous sample of one delayed copy of a second clock that is derived from the same reference. The block folds all taps into one parity bit per cycle. It then decimates by XOR-accumulating DECIM consecutive parity bits into one bit. If the corrector is enabled, it XORs non-overlapping pairs of those bits, which halves the rate. The finished bits are packed into bytes and offered with a one-cycle strobe to a downstream byte buffer.

DECIM follows from the ratio between the two clocks, so it is a parameter that goes together with the clock multiplication factor CLK_MULT. The two must be coprime. An odd DECIM gives the smaller worst-case edge spacing. The default is 22 taps, DECIM = 1272 and CLK_MULT = 785, so 27984 raw samples go into each decimated bit. At an 88.245 MHz system clock that gives roughly 69.4 kbit/s before the corrector.

Top module: `jitter_xor_postproc`

## Requirements
- R1: On each clock edge the NUM_TAPS tap bits are reduced to a single parity bit (XOR of all taps). This bit is the input to the decimator.
- R2: The decimator XORs the parity bits of DECIM consecutive cycles, in non-overlapping windows that start with the first clock edge after reset. It produces exactly one bit per window. The bit is registered and appears the cycle after the window's last edge.
- R3: The defaults are NUM_TAPS = 22, DECIM = 1272, CLK_MULT = 785 and corrector enabled. With the defaults, the first finished bit appears 2*DECIM + 1 cycles after reset release (cycle index 2544 counting the first active edge as 0). Elaboration stops when DECIM and CLK_MULT share a common factor.
- R4: With the corrector enabled, each finished bit is the XOR of two consecutive decimated bits taken as non-overlapping pairs. The finished bit appears the cycle after the second bit of the pair.
- R5: With the corrector disabled, the finished bit and its valid are the decimated bit and valid, with no added cycle.
- R6: Finished bits are packed LSB first: the first accepted bit goes to bit 0 and the eighth to bit 7. The byte strobe is a single-cycle pulse in the cycle after the eighth accepted bit.
- R7: A finished bit that arrives while ready_i is low is dropped and does not advance the packer. It sets a sticky overflow flag that only reset clears.
- R8: A synchronous active-low reset clears the decimation count, the accumulator, the pair state, the packer and all outputs to zero.
- R9: The finished-bit valid is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the taps |
| rst_n | input | 1 | Synchronous active-low reset |
| taps_i | input | NUM_TAPS | Sampled delay-line taps |
| ready_i | input | 1 | Downstream buffer can take bits |
| rnd_bit_o | output | 1 | Latest finished random bit |
| rnd_valid_o | output | 1 | Finished bit strobe |
| byte_o | output | WORD_W | Packed byte, LSB first |
| byte_valid_o | output | 1 | One-cycle byte strobe |
| overflow_o | output | 1 | Sticky flag: a bit was dropped |

## Verification
The taps are driven with all zeros and with all ones. These runs separate a correct parity fold from a stuck or inverted one, because an odd tap count must give a constant one. A walking single tap checks that every tap position reaches the parity. Biased random taps, with three ones in four, exercise the decimation windows and the pairing in the corrector, where an off-by-one window or a mispaired bit gives different output bits. A stretch with ready held low, followed by a reset in the middle of the run, covers dropped bits, the sticky flag and the restart of the window count. A default-sized instance confirms the output spacing of the full configuration.

// File: rtl/jxp_pkg.sv
// Package: shared types and elaboration helpers for the jitter post-processor.
// Assumes: used at elaboration time only for gcd_u; the struct carries a bit and its strobe.
package jxp_pkg;

    // A bit travelling through the pipeline together with its strobe.
    typedef struct packed {
        logic value;
        logic valid;
    } rbit_t;

    // Greatest common divisor. Bounded loop, enough for 32-bit operands.
    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        for (int k = 0; k < 64; k++) begin
            if (y != 0) begin
                t = x % y;
                x = y;
                y = t;
            end
        end
        return x;
    endfunction

endpackage

// File: rtl/jxp_tap_fold.sv
// Module: jxp_tap_fold
// Folds the sampled delay-line taps into one parity bit, combinationally.
// Assumes: taps are already synchronous to clk; NUM_TAPS >= 1.
module jxp_tap_fold #(
    parameter int NUM_TAPS = 22
) (
    input  logic [NUM_TAPS-1:0] taps_i,
    output logic                par_o
);

    generate
        if (NUM_TAPS == 1) begin : g_single
            // Purpose: a single tap is its own parity.
            always_comb par_o = taps_i[0];
        end else begin : g_tree
            // Purpose: XOR all taps into one bit.
            always_comb par_o = ^taps_i;
        end
    endgenerate

endmodule

// File: rtl/jxp_decimator.sv
// Module: jxp_decimator
// XOR-accumulates DECIM consecutive parity bits and emits one registered bit per window.
// Assumes: DECIM >= 2; the window starts on the first edge after reset release.
module jxp_decimator
    import jxp_pkg::*;
#(
    parameter int DECIM = 1272
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  par_i,
    output rbit_t dec_o
);

    localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

    logic [CW-1:0] cnt_q;
    logic          acc_q;
    logic          bit_q;
    logic          vld_q;

    // Purpose: window counter, running accumulator and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= 1'b0;
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            acc_q <= 1'b0;
            bit_q <= acc_q ^ par_i;
            vld_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= acc_q ^ par_i;
            vld_q <= 1'b0;
        end
    end

    // Purpose: expose the registered bit and strobe.
    always_comb begin
        dec_o.value = bit_q;
        dec_o.valid = vld_q;
    end

    // R2
    dec_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (cnt_q == '0));

endmodule

// File: rtl/jxp_pair_corrector.sv
// Module: jxp_pair_corrector
// XORs non-overlapping pairs of decimated bits; output rate is half the input rate.
// Assumes: input strobes are never back to back.
module jxp_pair_corrector
    import jxp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  rbit_t in_i,
    output rbit_t out_o
);

    logic have_q;
    logic first_q;
    logic bit_q;
    logic vld_q;

    // Purpose: hold the first bit of a pair and emit the XOR on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q  <= 1'b0;
            first_q <= 1'b0;
            bit_q   <= 1'b0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (in_i.valid) begin
                if (!have_q) begin
                    first_q <= in_i.value;
                    have_q  <= 1'b1;
                end else begin
                    bit_q  <= first_q ^ in_i.value;
                    vld_q  <= 1'b1;
                    have_q <= 1'b0;
                end
            end
        end
    end

    // Purpose: expose the corrected bit.
    always_comb begin
        out_o.value = bit_q;
        out_o.valid = vld_q;
    end

    logic in_vld;
    always_comb in_vld = in_i.valid;

    // R4
    pair_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(in_vld));

endmodule

// File: rtl/jxp_byte_packer.sv
// Module: jxp_byte_packer
// Packs finished bits LSB first into WORD_W-bit words with a one-cycle strobe.
// Assumes: bits arriving while ready_i is low are dropped and flagged, not held.
module jxp_byte_packer
    import jxp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rbit_t             in_i,
    input  logic              ready_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              overflow_o
);

    localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_W - 1);

    logic [IW-1:0]     idx_q;
    logic [WORD_W-1:0] part_q;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word_q;
    logic              vld_q;
    logic              ovf_q;

    // Purpose: the partial word with the incoming bit placed at its slot.
    always_comb begin
        merged        = part_q;
        merged[idx_q] = in_i.value;
    end

    // Purpose: accept or drop each bit, finish words, keep the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            part_q <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (in_i.valid) begin
                if (!ready_i) begin
                    ovf_q <= 1'b1;
                end else if (idx_q == LAST_IDX) begin
                    word_q <= merged;
                    vld_q  <= 1'b1;
                    idx_q  <= '0;
                    part_q <= '0;
                end else begin
                    part_q <= merged;
                    idx_q  <= idx_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        word_o     = word_q;
        valid_o    = vld_q;
        overflow_o = ovf_q;
    end

    logic in_vld;
    always_comb in_vld = in_i.valid;

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R6
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R6
    word_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> ($past(in_vld) && $past(ready_i)));

endmodule

// File: rtl/jitter_xor_postproc.sv
// Module: jitter_xor_postproc (top)
// Tap parity fold -> XOR decimator -> optional pair corrector -> byte packer.
// Assumes: DECIM coprime with CLK_MULT (checked at elaboration); DECIM >= 2.
module jitter_xor_postproc
    import jxp_pkg::*;
#(
    parameter int NUM_TAPS      = 22,
    parameter int DECIM         = 1272,
    parameter int CLK_MULT      = 785,
    parameter bit USE_CORRECTOR = 1'b1,
    parameter int WORD_W        = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  logic                ready_i,
    output logic                rnd_bit_o,
    output logic                rnd_valid_o,
    output logic [WORD_W-1:0]   byte_o,
    output logic                byte_valid_o,
    output logic                overflow_o
);

    localparam int unsigned RATIO_GCD = gcd_u(DECIM, CLK_MULT);

    generate
        if (RATIO_GCD != 1) begin : g_bad_ratio
            $error("DECIM and CLK_MULT must be coprime");
        end
        if (DECIM < 2) begin : g_bad_decim
            $error("DECIM must be at least 2");
        end
    endgenerate

    logic  par;
    rbit_t dec;
    rbit_t fin;

    jxp_tap_fold #(.NUM_TAPS(NUM_TAPS)) i_fold (
        .taps_i (taps_i),
        .par_o  (par)
    );

    jxp_decimator #(.DECIM(DECIM)) i_decim (
        .clk   (clk),
        .rst_n (rst_n),
        .par_i (par),
        .dec_o (dec)
    );

    generate
        if (USE_CORRECTOR) begin : g_corr
            jxp_pair_corrector i_corr (
                .clk   (clk),
                .rst_n (rst_n),
                .in_i  (dec),
                .out_o (fin)
            );
        end else begin : g_pass
            // Purpose: without the corrector the decimated bit is final.
            always_comb fin = dec;
        end
    endgenerate

    jxp_byte_packer #(.WORD_W(WORD_W)) i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_i       (fin),
        .ready_i    (ready_i),
        .word_o     (byte_o),
        .valid_o    (byte_valid_o),
        .overflow_o (overflow_o)
    );

    // Purpose: drive the finished-bit ports.
    always_comb begin
        rnd_bit_o   = fin.value;
        rnd_valid_o = fin.valid;
    end

    // R9
    rnd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid_o |=> !rnd_valid_o);

endmodule

// File: tb/test_jitter_xor_postproc.sv
module test_jitter_xor_postproc;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n;
    logic [21:0] taps;
    logic        ready;

    logic [2:0]  rb, rv, bvo, ovo;
    logic [7:0]  byo [3];

    // inst 0: small, corrector on; inst 1: small, corrector off; inst 2: defaults
    jitter_xor_postproc #(.NUM_TAPS(5), .DECIM(7), .CLK_MULT(5), .USE_CORRECTOR(1'b1)) i_jitter_xor_postproc (
        .clk(clk), .rst_n(rst_n), .taps_i(taps[4:0]), .ready_i(ready),
        .rnd_bit_o(rb[0]), .rnd_valid_o(rv[0]), .byte_o(byo[0]),
        .byte_valid_o(bvo[0]), .overflow_o(ovo[0]));

    jitter_xor_postproc #(.NUM_TAPS(5), .DECIM(4), .CLK_MULT(3), .USE_CORRECTOR(1'b0)) i_jitter_xor_postproc_nc (
        .clk(clk), .rst_n(rst_n), .taps_i(taps[4:0]), .ready_i(ready),
        .rnd_bit_o(rb[1]), .rnd_valid_o(rv[1]), .byte_o(byo[1]),
        .byte_valid_o(bvo[1]), .overflow_o(ovo[1]));

    jitter_xor_postproc i_jitter_xor_postproc_def (
        .clk(clk), .rst_n(rst_n), .taps_i(taps), .ready_i(ready),
        .rnd_bit_o(rb[2]), .rnd_valid_o(rv[2]), .byte_o(byo[2]),
        .byte_valid_o(bvo[2]), .overflow_o(ovo[2]));

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Reference model state, one slot per instance
    int md [3] = '{7, 4, 1272};
    int mc [3] = '{1, 0, 1};
    int mn [3] = '{5, 5, 22};
    int m_cnt [3] = '{0, 0, 0};
    int m_acc [3] = '{0, 0, 0};
    int m_dv  [3] = '{0, 0, 0};
    int m_db  [3] = '{0, 0, 0};
    int m_hf  [3] = '{0, 0, 0};
    int m_fb  [3] = '{0, 0, 0};
    int m_cv  [3] = '{0, 0, 0};
    int m_cb  [3] = '{0, 0, 0};
    int m_bits[3][$];
    int m_bv  [3] = '{0, 0, 0};
    int m_by  [3] = '{0, 0, 0};
    int m_ov  [3] = '{0, 0, 0};
    int prev_rv [3] = '{0, 0, 0};
    int first_def = -1;
    int first_nc  = -1;

    function automatic int parity(input logic [21:0] t, input int n);
        int p = 0;
        for (int k = 0; k < n; k++) p = p ^ int'(t[k]);
        return p;
    endfunction

    // Behavioural model: queue of accepted bits forms each byte
    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!rst_n) begin
                m_cnt[i] = 0; m_acc[i] = 0; m_dv[i] = 0; m_db[i] = 0;
                m_hf[i] = 0; m_fb[i] = 0; m_cv[i] = 0; m_cb[i] = 0;
                m_bits[i].delete(); m_bv[i] = 0; m_by[i] = 0; m_ov[i] = 0;
            end else begin
                int fv, fb, x;
                fv = (mc[i] != 0) ? m_cv[i] : m_dv[i];
                fb = (mc[i] != 0) ? m_cb[i] : m_db[i];
                m_bv[i] = 0;
                if (fv != 0) begin
                    if (!ready) m_ov[i] = 1;
                    else begin
                        m_bits[i].push_back(fb);
                        if (m_bits[i].size() == 8) begin
                            m_by[i] = 0;
                            for (int k = 0; k < 8; k++) m_by[i] = m_by[i] | (m_bits[i][k] << k);
                            m_bits[i].delete();
                            m_bv[i] = 1;
                        end
                    end
                end
                if (mc[i] != 0) begin
                    m_cv[i] = 0;
                    if (m_dv[i] != 0) begin
                        if (m_hf[i] == 0) begin m_fb[i] = m_db[i]; m_hf[i] = 1; end
                        else begin m_cb[i] = m_fb[i] ^ m_db[i]; m_cv[i] = 1; m_hf[i] = 0; end
                    end
                end
                x = parity(taps, mn[i]);
                m_dv[i] = 0;
                if (m_cnt[i] == md[i] - 1) begin
                    m_db[i] = m_acc[i] ^ x; m_dv[i] = 1; m_acc[i] = 0; m_cnt[i] = 0;
                end else begin
                    m_acc[i] = m_acc[i] ^ x; m_cnt[i]++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic reset_check();
        for (int i = 0; i < 3; i++) begin
            chk(rv[i] == 0 && bvo[i] == 0 && ovo[i] == 0 && rb[i] == 0, "R8", $sformatf("inst%0d strobes/flag after reset", i),
                int'({rv[i], bvo[i], ovo[i], rb[i]}), 0);
            chk(byo[i] == 8'h00, "R8", $sformatf("inst%0d byte after reset", i), int'(byo[i]), 0);
        end
    endtask

    task automatic compare(input int c, input bit first_run);
        for (int i = 0; i < 3; i++) begin
            int ev, eb;
            string tb_tag;
            ev = (mc[i] != 0) ? m_cv[i] : m_dv[i];
            eb = (mc[i] != 0) ? m_cb[i] : m_db[i];
            chk(int'(rv[i]) == ev, (i == 2) ? "R3" : "R2", $sformatf("inst%0d bit strobe c=%0d", i, c), int'(rv[i]), ev);
            if (ev != 0) begin
                if (i == 0) tb_tag = "R4";
                else if (i == 2) tb_tag = "R3";
                else if (c >= 0 && c < 160) tb_tag = "R1";   // R1: fixed and walking tap patterns
                else tb_tag = "R5";
                chk(int'(rb[i]) == eb, tb_tag, $sformatf("inst%0d bit value c=%0d", i, c), int'(rb[i]), eb);
            end
            chk(int'(bvo[i]) == m_bv[i], "R6", $sformatf("inst%0d byte strobe c=%0d", i, c), int'(bvo[i]), m_bv[i]);
            if (m_bv[i] != 0)
                chk(int'(byo[i]) == m_by[i], "R6", $sformatf("inst%0d byte c=%0d", i, c), int'(byo[i]), m_by[i]);
            chk(int'(ovo[i]) == m_ov[i], "R7", $sformatf("inst%0d overflow c=%0d", i, c), int'(ovo[i]), m_ov[i]);
            // R9: no back-to-back strobes
            chk(!(rv[i] && prev_rv[i] != 0), "R9", $sformatf("inst%0d consecutive strobes c=%0d", i, c), int'(rv[i]), 0);
            prev_rv[i] = int'(rv[i]);
            if (first_run && rv[i] && i == 2 && first_def < 0) first_def = c;
            if (first_run && rv[i] && i == 1 && first_nc < 0) first_nc = c;
        end
    endtask

    task automatic drive(input int c);
        logic [21:0] t;
        ready = !(c >= 600 && c < 700);
        if (c < 40) t = '0;
        else if (c < 80) t = '1;
        else if (c < 160) t = 22'(1) << (c % 5);
        else begin
            for (int k = 0; k < 22; k++) t[k] = ($urandom % 4) != 0;
        end
        taps = t;
    endtask

    initial begin
        void'($urandom(7));
        rst_n = 1'b0; taps = '0; ready = 1'b1;
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        for (int c = 0; c < 3200; c++) begin
            drive(c);
            @(negedge clk);
            compare(c, 1'b1);
            if (c == 700) chk(ovo[0] == 1'b1, "R7", "inst0 sticky overflow after ready low", int'(ovo[0]), 1);
        end
        chk(first_nc == 3, "R2", "first decimated bit cycle (DECIM=4)", first_nc, 3);
        chk(first_def == 2544, "R3", "first finished bit cycle at defaults", first_def, 2544);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        reset_check();
        for (int i = 0; i < 3; i++) prev_rv[i] = 0;
        rst_n = 1'b1;
        for (int c = 0; c < 200; c++) begin
            drive(c + 160);
            @(negedge clk);
            compare(c + 160, 1'b0);
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule